// File: doc/BRIEF.md
# Delayed Register-Write Retirement Queue

This block holds register updates that must land a fixed number of cycles after the operation that produced them, such as a condition flag that only becomes visible some time after issue. A producer pushes an update through a single push port. The update names a destination register, a write kind, a bit position, a value and a delay. The entries sit in a ring of slots. On every cycle with the `tick` input high, each waiting entry counts its delay down by one. When the count expires, the entry performs its write into a small 64-bit register file, which has a combinational read port.

There are two kinds of write. A single-bit write sets or clears one bit of the destination. A word write replaces either the low 32 bits or the full 64 bits. Entries may expire in any order, but a slot is freed only in order from the oldest entry. An entry that expires early therefore keeps its slot until every older entry has also expired. An internal consistency monitor raises a sticky error flag if the ring pointers ever disagree with the occupancy count.

Top module: `delayed_write_queue`

## Requirements
- R1: After synchronous reset, `occupancy` is 0, `push_full` is 0, `fatal_err` is 0 and every register reads 0.
- R2: A push taken while `occupancy` is below SLOTS adds one entry, so `occupancy` rises by one in the next cycle unless entries retire in that cycle. When `occupancy` equals SLOTS, `push_full` is high and a push is refused. A refused push is never stored and its write never appears in the register file, even if entries retire in that same cycle.
- R3: Delays count down only on cycles with `tick` high. An entry pushed with delay d ≥ 1 performs its write on the d-th tick after its push cycle, and the new value is visible on `rd_data` from the following cycle onward. A pushed delay of 0 behaves as 1.
- R4: Write kind 0 (`push_kind`=2'd0) is a bit write. If bit 0 of the value is 1, bit `push_bpos` of the destination is set. If bit 0 of the value is 0, that bit is cleared. All other bits keep their values.
- R5: Write kind 1 replaces bits 31:0 of the destination and keeps bits 63:32. Write kinds 2 and 3 replace all 64 bits.
- R6: When several entries expire on the same tick, their writes are applied oldest first. If two of them target the same register, the younger write wins.
- R7: `occupancy` falls only by the length of the unbroken run of expired entries that starts at the oldest entry. On cycles without `tick`, it never falls.
- R8: `fatal_err` is sticky. It rises if the in and out pointers differ while the occupancy count is zero, and it stays low in consistent operation.
- R9: When a push and a tick happen in the same cycle, the tick decrements only the entries that were already queued. The new entry starts from its full delay.
- R10: `rd_data` shows the register selected by `rd_addr` combinationally, and registers change only on a tick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push request |
| push_dst | input | 4 | Destination register index |
| push_kind | input | 2 | 0 bit write, 1 low-32 write, 2/3 full-64 write |
| push_bpos | input | 6 | Bit position for bit writes |
| push_value | input | 64 | Write value (bit 0 only for bit writes) |
| push_delay | input | 5 | Ticks until the write (0 treated as 1) |
| push_full | output | 1 | Ring full; a push is refused |
| tick | input | 1 | Countdown step |
| rd_addr | input | 4 | Read register index |
| rd_data | output | 64 | Read data |
| occupancy | output | 3 | Entries held in the ring |
| fatal_err | output | 1 | Sticky pointer/count inconsistency |

## Verification
The assertions assume that `rst` is held high through the first clock edge, and that `rd_addr` changes only between edges. The bench drives every input just after a falling edge, so both assumptions hold. The properties also assume that no write lands on a cycle without a tick. The bench lets the register file change only through ticks, and it holds `tick` low for whole cycles when it needs the register contents to stay still. Pushes arrive in full, refused and mixed conditions, including pushes with delay 0, and the bench issues them both with and without a tick in the same cycle.

// File: rtl/dwq_pkg.sv
package dwq_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = 32;
    localparam int BPOS_W = 6;
    localparam int RIDX_W = 4;
    localparam int DLY_W  = 5;

    typedef enum logic [1:0] {
        WK_BIT    = 2'd0,
        WK_LOW32  = 2'd1,
        WK_FULL   = 2'd2,
        WK_FULL_B = 2'd3
    } wkind_e;

    typedef struct packed {
        logic              live;
        logic              done;
        logic [RIDX_W-1:0] dst;
        wkind_e            kind;
        logic [BPOS_W-1:0] bpos;
        logic [DATA_W-1:0] val;
        logic [DLY_W-1:0]  dly;
    } slot_t;

    typedef struct packed {
        logic              en;
        logic [RIDX_W-1:0] dst;
        wkind_e            kind;
        logic [BPOS_W-1:0] bpos;
        logic [DATA_W-1:0] val;
    } wreq_t;

    // position k places after p in a ring of n slots
    function automatic int ring_add(input int p, input int k, input int n);
        int s;
        s = p + k;
        if (s >= n) s = s - n;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] merge_write(
        input logic [DATA_W-1:0] old,
        input wreq_t             w
    );
        logic [DATA_W-1:0] m;
        logic [DATA_W-1:0] r;
        m = {{(DATA_W-1){1'b0}}, 1'b1} << w.bpos;
        case (w.kind)
            WK_BIT:   r = w.val[0] ? (old | m) : (old & ~m);
            WK_LOW32: r = {old[DATA_W-1:HALF_W], w.val[HALF_W-1:0]};
            default:  r = w.val;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dwq_sched.sv
module dwq_sched
    import dwq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  slot_t          slots [SLOTS],
    input  logic [PW-1:0]  out_ptr,
    input  logic [CW-1:0]  count,
    input  logic           tick,
    output logic [SLOTS-1:0] expire,
    output wreq_t          wlist [SLOTS],
    output logic [CW-1:0]  retire_n
);

    always_comb begin
        logic        run;
        logic        fire;
        logic [PW-1:0] idx;
        expire   = '0;
        retire_n = '0;
        run      = 1'b1;
        for (int k = 0; k < SLOTS; k++) begin
            wlist[k] = '0;
            idx      = PW'(ring_add(int'(out_ptr), k, SLOTS));
            fire     = 1'b0;
            if (CW'(k) < count) begin
                fire = tick && slots[idx].live && !slots[idx].done
                       && (slots[idx].dly == DLY_W'(1));
                if (fire) begin
                    expire[idx]    = 1'b1;
                    wlist[k].en    = 1'b1;
                    wlist[k].dst   = slots[idx].dst;
                    wlist[k].kind  = slots[idx].kind;
                    wlist[k].bpos  = slots[idx].bpos;
                    wlist[k].val   = slots[idx].val;
                end
                if (run && (slots[idx].done || fire))
                    retire_n = retire_n + CW'(1);
                else
                    run = 1'b0;
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dwq_ring.sv
module dwq_ring
    import dwq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_ok,
    input  slot_t            push_slot,
    input  logic             tick,
    input  logic [SLOTS-1:0] expire,
    input  logic [CW-1:0]    retire_n,
    output slot_t            slots [SLOTS],
    output logic [PW-1:0]    in_ptr,
    output logic [PW-1:0]    out_ptr,
    output logic [CW-1:0]    count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
            in_ptr  <= '0;
            out_ptr <= '0;
            count   <= '0;
        end else begin
            // countdown of entries already queued
            for (int i = 0; i < SLOTS; i++) begin
                if (tick && slots[i].live && !slots[i].done) begin
                    if (expire[i]) slots[i].done <= 1'b1;
                    else           slots[i].dly  <= slots[i].dly - DLY_W'(1);
                end
            end
            // in-order release from the oldest slot
            for (int k = 0; k < SLOTS; k++) begin
                if (CW'(k) < retire_n)
                    slots[PW'(ring_add(int'(out_ptr), k, SLOTS))] <= '0;
            end
            if (push_ok) begin
                slots[in_ptr] <= push_slot;
                in_ptr        <= PW'(ring_add(int'(in_ptr), 1, SLOTS));
            end
            out_ptr <= PW'(ring_add(int'(out_ptr), int'(retire_n), SLOTS));
            count   <= count + CW'(push_ok) - retire_n;
        end
    end

endmodule

// File: rtl/dwq_regfile.sv
module dwq_regfile
    import dwq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int AW    = RIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wreq_t             wlist [SLOTS],
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NREGS = 1 << AW;

    logic [DATA_W-1:0] rf_q   [NREGS];
    logic [DATA_W-1:0] rf_nxt [NREGS];

    // writes applied oldest first so the youngest one lands last
    always_comb begin
        for (int r = 0; r < NREGS; r++) rf_nxt[r] = rf_q[r];
        for (int k = 0; k < SLOTS; k++) begin
            if (wlist[k].en)
                rf_nxt[AW'(wlist[k].dst)] = merge_write(rf_nxt[AW'(wlist[k].dst)], wlist[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREGS; r++) rf_q[r] <= '0;
        end else begin
            for (int r = 0; r < NREGS; r++) rf_q[r] <= rf_nxt[r];
        end
    end

    assign rd_data = rf_q[rd_addr];

endmodule

// File: rtl/delayed_write_queue.sv
module delayed_write_queue
    import dwq_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_valid,
    input  logic [RIDX_W-1:0]    push_dst,
    input  logic [1:0]           push_kind,
    input  logic [BPOS_W-1:0]    push_bpos,
    input  logic [DATA_W-1:0]    push_value,
    input  logic [DLY_W-1:0]     push_delay,
    output logic                 push_full,
    input  logic                 tick,
    input  logic [RIDX_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [$clog2(SLOTS+1)-1:0] occupancy,
    output logic                 fatal_err
);

    localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CW = $clog2(SLOTS + 1);

    slot_t            slots [SLOTS];
    wreq_t            wlist [SLOTS];
    logic [PW-1:0]    in_ptr;
    logic [PW-1:0]    out_ptr;
    logic [CW-1:0]    count;
    logic [SLOTS-1:0] expire;
    logic [CW-1:0]    retire_n;
    logic             push_ok;
    slot_t            push_slot;
    logic             fatal_q;

    assign push_full = (count == CW'(SLOTS));
    assign push_ok   = push_valid && !push_full;

    always_comb begin
        push_slot      = '0;
        push_slot.live = 1'b1;
        push_slot.dst  = push_dst;
        push_slot.kind = wkind_e'(push_kind);
        push_slot.bpos = push_bpos;
        push_slot.val  = push_value;
        push_slot.dly  = (push_delay == '0) ? DLY_W'(1) : push_delay;
    end

    dwq_sched #(.SLOTS(SLOTS), .PW(PW), .CW(CW)) u_sched (
        .slots    (slots),
        .out_ptr  (out_ptr),
        .count    (count),
        .tick     (tick),
        .expire   (expire),
        .wlist    (wlist),
        .retire_n (retire_n)
    );

    dwq_ring #(.SLOTS(SLOTS), .PW(PW), .CW(CW)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push_ok   (push_ok),
        .push_slot (push_slot),
        .tick      (tick),
        .expire    (expire),
        .retire_n  (retire_n),
        .slots     (slots),
        .in_ptr    (in_ptr),
        .out_ptr   (out_ptr),
        .count     (count)
    );

    dwq_regfile #(.SLOTS(SLOTS), .AW(RIDX_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wlist   (wlist),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            fatal_q <= 1'b0;
        else if ((count == '0) && (in_ptr != out_ptr))
            fatal_q <= 1'b1;
    end

    assign fatal_err = fatal_q;
    assign occupancy = count;

endmodule

// File: rtl/dwq_checker.sv
module dwq_checker #(
    parameter int SLOTS = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          push_valid,
    input logic          push_full,
    input logic [CW-1:0] occupancy,
    input logic [3:0]    rd_addr,
    input logic [63:0]   rd_data,
    input logic          fatal_err
);

    p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
        occupancy <= CW'(SLOTS));

    p_refuse_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_full && !tick) |=> occupancy == $past(occupancy));

    p_grow_one_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> occupancy <= $past(occupancy) + CW'(1));

    p_idle_regs_r10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));

    p_no_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> occupancy >= $past(occupancy));

    p_consistent_r8: assert property (@(posedge clk) disable iff (rst)
        !fatal_err);

endmodule

bind delayed_write_queue dwq_checker #(.SLOTS(SLOTS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .push_valid (push_valid),
    .push_full  (push_full),
    .occupancy  (occupancy),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .fatal_err  (fatal_err)
);

// File: tb/delayed_write_queue_tb.sv
module delayed_write_queue_tb;

    localparam int SLOTS = 4;
    localparam int CW    = $clog2(SLOTS + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [3:0]  push_dst = '0;
    logic [1:0]  push_kind = '0;
    logic [5:0]  push_bpos = '0;
    logic [63:0] push_value = '0;
    logic [4:0]  push_delay = '0;
    logic        push_full;
    logic        tick = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic [CW-1:0] occupancy;
    logic        fatal_err;

    always #5 clk = ~clk;

    delayed_write_queue #(.SLOTS(SLOTS)) u_dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_dst(push_dst),
        .push_kind(push_kind), .push_bpos(push_bpos), .push_value(push_value),
        .push_delay(push_delay), .push_full(push_full), .tick(tick),
        .rd_addr(rd_addr), .rd_data(rd_data), .occupancy(occupancy),
        .fatal_err(fatal_err)
    );

    typedef struct {
        int          dst;
        int          kind;
        int          bpos;
        logic [63:0] val;
        int          dly;
        bit          done;
    } ment_t;

    ment_t       mq[$];
    logic [63:0] mrf [16];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          watch    = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_merge(input logic [63:0] old, input ment_t e);
        logic [63:0] m;
        m = 64'd1 << e.bpos;
        if (e.kind == 0)      return e.val[0] ? (old | m) : (old & ~m);
        else if (e.kind == 1) return {old[63:32], e.val[31:0]};
        else                  return e.val;
    endfunction

    // one clock: called just after a falling edge
    task automatic step(input bit pv, input int dst, input int kind, input int bpos,
                        input logic [63:0] val, input int dly, input bit tk);
        bit acc;
        ment_t e;
        push_valid = pv;
        push_dst   = 4'(dst);
        push_kind  = 2'(kind);
        push_bpos  = 6'(bpos);
        push_value = val;
        push_delay = 5'(dly);
        tick       = tk;
        rd_addr    = 4'(watch);
        #1;
        chk("R2 push_full", 64'(push_full), 64'(mq.size() == SLOTS));
        acc = pv && (mq.size() < SLOTS);
        @(posedge clk);
        if (tk) begin
            for (int i = 0; i < mq.size(); i++) begin
                if (!mq[i].done) begin
                    mq[i].dly--;
                    if (mq[i].dly == 0) begin
                        mrf[mq[i].dst] = model_merge(mrf[mq[i].dst], mq[i]);
                        mq[i].done = 1'b1;
                    end
                end
            end
            while (mq.size() > 0 && mq[0].done) void'(mq.pop_front());
        end
        if (acc) begin
            e.dst = dst; e.kind = kind; e.bpos = bpos; e.val = val;
            e.dly = (dly == 0) ? 1 : dly; e.done = 1'b0;
            mq.push_back(e);
        end
        @(negedge clk);
        push_valid = 1'b0;
        tick       = 1'b0;
        #1;
        chk("R7 occupancy", 64'(occupancy), 64'(mq.size()));
        chk("R8 fatal_err", 64'(fatal_err), 64'd0);
        chk("R10 model rd_data", rd_data, mrf[watch]);
        watch = (watch + 1) % 16;
    endtask

    task automatic pushw(input int dst, input int kind, input int bpos,
                         input logic [63:0] val, input int dly, input bit tk);
        step(1'b1, dst, kind, bpos, val, dly, tk);
    endtask

    task automatic tk1();
        step(1'b0, 0, 0, 0, 64'd0, 0, 1'b1);
    endtask

    task automatic rd(input int r, output logic [63:0] v);
        rd_addr = 4'(r);
        #1;
        v = rd_data;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [63:0] a;
        for (int r = 0; r < 16; r++) mrf[r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 occupancy", 64'(occupancy), 64'd0);
        chk("R1 push_full", 64'(push_full), 64'd0);
        chk("R1 fatal_err", 64'(fatal_err), 64'd0);
        for (int r = 0; r < 16; r++) begin
            rd(r, v);
            chk("R1 reg zero", v, 64'd0);
        end
        @(negedge clk);

        // R3/R5 full write after three ticks
        a = 64'hA5A5_0001_DEAD_BEEF;
        pushw(1, 2, 0, a, 3, 1'b0);
        chk("R2 occupancy after push", 64'(occupancy), 64'd1);
        tk1(); tk1();
        rd(1, v); chk("R3 not yet written", v, 64'd0);
        step(1'b0, 0, 0, 0, 64'd0, 0, 1'b0);
        rd(1, v); chk("R3 no countdown without tick", v, 64'd0);
        tk1();
        rd(1, v); chk("R3 written on third tick", v, a);

        // R9 push together with tick; R5 low-32 write
        pushw(1, 1, 0, 64'hFFFF_FFFF_1234_5678, 1, 1'b1);
        rd(1, v); chk("R9 push-cycle tick ignored", v, a);
        tk1();
        rd(1, v); chk("R5 low32 write", v, {a[63:32], 32'h1234_5678});

        // R4 bit set and clear; R5 kind 3
        pushw(2, 0, 40, 64'd1, 1, 1'b0);
        tk1();
        rd(2, v); chk("R4 bit set", v, 64'd1 << 40);
        pushw(2, 0, 3, 64'd1, 1, 1'b0);
        tk1();
        pushw(2, 0, 40, 64'd0, 1, 1'b0);
        tk1();
        rd(2, v); chk("R4 bit clear keeps others", v, 64'd8);
        pushw(8, 3, 0, 64'h0123_4567_89AB_CDEF, 1, 1'b0);
        tk1();
        rd(8, v); chk("R5 kind3 full write", v, 64'h0123_4567_89AB_CDEF);

        // R7 in-order release
        pushw(3, 2, 0, 64'h33, 5, 1'b0);
        pushw(4, 2, 0, 64'h44, 1, 1'b0);
        tk1();
        rd(4, v); chk("R7 younger written early", v, 64'h44);
        chk("R7 slot still held", 64'(occupancy), 64'd2);
        repeat (3) tk1();
        chk("R7 still two", 64'(occupancy), 64'd2);
        tk1();
        chk("R7 both released", 64'(occupancy), 64'd0);
        rd(3, v); chk("R7 older written", v, 64'h33);

        // R6 same-tick expiry, younger wins
        pushw(5, 2, 0, 64'h1111, 2, 1'b0);
        pushw(5, 2, 0, 64'h2222, 2, 1'b0);
        tk1(); tk1();
        rd(5, v); chk("R6 younger wins", v, 64'h2222);

        // R3 delay 0 behaves as 1
        pushw(9, 2, 0, 64'h99, 0, 1'b0);
        tk1();
        rd(9, v); chk("R3 delay zero as one", v, 64'h99);

        // R2 full ring refuses pushes
        for (int i = 0; i < SLOTS; i++) pushw(6, 2, 0, 64'(i + 1), 2 + i, 1'b0);
        chk("R2 full flag", 64'(push_full), 64'd1);
        pushw(7, 2, 0, 64'h7777, 1, 1'b0);
        chk("R2 refused push", 64'(occupancy), 64'(SLOTS));
        pushw(7, 2, 0, 64'h7778, 1, 1'b1);
        repeat (6) tk1();
        rd(7, v); chk("R2 refused never written", v, 64'd0);
        rd(6, v); chk("R2 last accepted written", v, 64'(SLOTS));
        chk("R2 drained", 64'(occupancy), 64'd0);

        // mixed random traffic against the model
        for (int n = 0; n < 400; n++) begin
            step(($urandom_range(0, 2) != 0), $urandom_range(0, 15), $urandom_range(0, 3),
                 $urandom_range(0, 63), {$urandom, $urandom}, $urandom_range(0, 6),
                 ($urandom_range(0, 2) != 0));
        end
        repeat (10) tk1();
        for (int r = 0; r < 16; r++) begin
            rd(r, v);
            chk("R10 final register", v, mrf[r]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule